// File: doc/BRIEF.md
# Full-frame CCD clock sequencer

This block produces the logic-level timing for a two-phase full-frame CCD over one complete frame. A start command opens an exposure window of programmable length in which both vertical phases rest low. Readout then proceeds one line at a time. Each line begins with a three-step vertical transfer that moves a row of charge into the horizontal register, followed by a set-up gap. A burst of horizontal pixel clocks then empties that register through the output node. A reset-gate pulse and an ADC sample strobe are placed inside every pixel period.

All durations are counts of the system clock. The exposure length, vertical pulse width, set-up gap and pixel period are captured when a start command is accepted and stay fixed until the frame ends. Status outputs show that a frame is in flight, that exposure is running, that a line has finished and that the frame has finished. Level shifting, clock drivers and the converter are outside the block.

Top module: `fullframe_clkseq`

## Requirements
- R1: After reset and whenever idle: V1=0, V2=0, H1=1, H2=0, RG=0, sample=0, busy=0, integrating=0, eol=0, eof=0.
- R2: A start seen in idle makes busy and integrating high from the next cycle. Integrating lasts exactly the programmed exposure count, where 0 counts as 1, and V1 and V2 are low throughout it.
- R3: Each line begins with V1 high for W cycles, then V2 high for W cycles, then both low for W cycles, where W is the programmed pulse width and 0 counts as 1. V1 and V2 are never high together.
- R4: H1 is high and H2 is low through the vertical transfer and the set-up gap, so H1 is high at every falling edge of V2. The gap lasts the programmed set-up count, where 0 counts as 1.
- R5: Readout of a line is NPIX pixels of P cycles each, with P = max(programmed period, 4). In pixel cycle k (0..P-1), H2 is high for k < floor(P/2) and H1 is the complement of H2.
- R6: RG is high only in cycle k=0 of each pixel, for one cycle, and never outside readout.
- R7: Sample is high only in cycle k=P-1 of each pixel. That places it after H2 falls and before the next RG pulse, and it is never high during vertical transfer, set-up or exposure.
- R8: A frame holds LINES lines. The time between two end-of-line pulses of one frame equals 3*W + set-up + NPIX*P cycles.
- R9: End-of-line is a one-cycle pulse in the cycle after the last pixel of every line. End-of-frame is a one-cycle pulse in the same cycle as the final end-of-line, and busy is already low in that cycle.
- R10: A start while busy is ignored. Configuration inputs are taken only at an accepted start, so changing them mid-frame does not alter the frame.
- R11: A start held in the end-of-frame cycle is accepted, and the next exposure begins in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start-exposure command, sampled while idle |
| integ_len_i | input | INT_W | Exposure length in clocks |
| vpw_i | input | VPW_W | Vertical pulse width in clocks |
| setup_i | input | SET_W | Horizontal set-up gap in clocks |
| pix_per_i | input | PP_W | Pixel period in clocks (minimum 4) |
| v1_o | output | 1 | Vertical phase 1 |
| v2_o | output | 1 | Vertical phase 2 |
| h1_o | output | 1 | Horizontal phase 1 |
| h2_o | output | 1 | Horizontal phase 2 |
| rg_o | output | 1 | Reset-gate clock |
| sample_o | output | 1 | Per-pixel ADC sample strobe |
| busy_o | output | 1 | Frame in progress |
| integ_o | output | 1 | Exposure in progress |
| eol_o | output | 1 | End-of-line pulse |
| eof_o | output | 1 | End-of-frame pulse |

## Verification
Two events can share a cycle: the end-of-frame pulse, and a new start command that the now-idle sequencer must accept. The bench raises start in exactly the cycle of the final end-of-line pulse. It expects that cycle to show eol, eof and idle levels, and the next cycle to begin the second frame's exposure with that frame's own timing. End-of-line also coincides with the first V1-high cycle of the next line, and the cycle-by-cycle scoreboard judges that coincidence.

// File: rtl/clkseq_pkg.sv
package clkseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_INTEG = 3'd1,
    ST_VXFER = 3'd2,
    ST_SETUP = 3'd3,
    ST_READ  = 3'd4
  } seq_state_e;

  localparam int unsigned MIN_PIX_PER = 4;

  // raise a programmed count to a floor value
  function automatic int unsigned at_least(input int unsigned v, input int unsigned lo);
    return (v < lo) ? lo : v;
  endfunction

  // number of leading pixel cycles with H2 high
  function automatic int unsigned h2_span(input int unsigned per);
    return per / 2;
  endfunction

  // cycles per line: three vertical widths, set-up gap, pixel burst
  function automatic int unsigned line_cycles(input int unsigned vpw, input int unsigned setup,
                                              input int unsigned per, input int unsigned npix);
    return 3 * vpw + setup + npix * per;
  endfunction

endpackage

// File: rtl/clkseq_frame_ctl.sv
module clkseq_frame_ctl
  import clkseq_pkg::*;
#(
  parameter int LINES = 2056,
  parameter int INT_W = 24,
  parameter int VPW_W = 16,
  parameter int SET_W = 16,
  parameter int PP_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [INT_W-1:0] integ_len_i,
  input  logic [VPW_W-1:0] vpw_i,
  input  logic [SET_W-1:0] setup_i,
  input  logic [PP_W-1:0]  pix_per_i,
  input  logic             line_done_i,
  output seq_state_e       state_o,
  output logic [1:0]       vseg_o,
  output logic [VPW_W-1:0] vpw_o,
  output logic [SET_W-1:0] set_o,
  output logic [PP_W-1:0]  per_o,
  output logic             eol_o,
  output logic             eof_o
);
  localparam int LINE_W = (LINES > 1) ? $clog2(LINES) : 1;
  localparam int SEG_W  = (INT_W > VPW_W) ? ((INT_W > SET_W) ? INT_W : SET_W)
                                          : ((VPW_W > SET_W) ? VPW_W : SET_W);

  seq_state_e        state_q;
  logic [SEG_W-1:0]  seg_cnt;
  logic [SEG_W-1:0]  seg_lim;
  logic              seg_last;
  logic [1:0]        vseg_q;
  logic [LINE_W-1:0] line_cnt;
  logic              last_line;
  logic [INT_W-1:0]  int_q;
  logic [VPW_W-1:0]  vpw_q;
  logic [SET_W-1:0]  set_q;
  logic [PP_W-1:0]   per_q;
  logic              eol_q;
  logic              eof_q;

  always_comb begin
    case (state_q)
      ST_INTEG: seg_lim = SEG_W'(int_q);
      ST_VXFER: seg_lim = SEG_W'(vpw_q);
      ST_SETUP: seg_lim = SEG_W'(set_q);
      default:  seg_lim = '1;
    endcase
  end

  assign seg_last  = (seg_cnt == seg_lim - SEG_W'(1));
  assign last_line = (line_cnt == LINE_W'(LINES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      seg_cnt  <= '0;
      vseg_q   <= '0;
      line_cnt <= '0;
      int_q    <= INT_W'(1);
      vpw_q    <= VPW_W'(1);
      set_q    <= SET_W'(1);
      per_q    <= PP_W'(MIN_PIX_PER);
      eol_q    <= 1'b0;
      eof_q    <= 1'b0;
    end else begin
      eol_q <= 1'b0;
      eof_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            int_q    <= INT_W'(at_least(32'(integ_len_i), 1));
            vpw_q    <= VPW_W'(at_least(32'(vpw_i), 1));
            set_q    <= SET_W'(at_least(32'(setup_i), 1));
            per_q    <= PP_W'(at_least(32'(pix_per_i), MIN_PIX_PER));
            seg_cnt  <= '0;
            line_cnt <= '0;
            state_q  <= ST_INTEG;
          end
        end
        ST_INTEG: begin
          if (seg_last) begin
            seg_cnt <= '0;
            vseg_q  <= '0;
            state_q <= ST_VXFER;
          end else begin
            seg_cnt <= seg_cnt + SEG_W'(1);
          end
        end
        ST_VXFER: begin
          if (seg_last) begin
            seg_cnt <= '0;
            if (vseg_q == 2'd2) state_q <= ST_SETUP;
            else                vseg_q  <= vseg_q + 2'd1;
          end else begin
            seg_cnt <= seg_cnt + SEG_W'(1);
          end
        end
        ST_SETUP: begin
          if (seg_last) begin
            seg_cnt <= '0;
            state_q <= ST_READ;
          end else begin
            seg_cnt <= seg_cnt + SEG_W'(1);
          end
        end
        ST_READ: begin
          if (line_done_i) begin
            eol_q  <= 1'b1;
            vseg_q <= '0;
            if (last_line) begin
              eof_q    <= 1'b1;
              line_cnt <= '0;
              state_q  <= ST_IDLE;
            end else begin
              line_cnt <= line_cnt + LINE_W'(1);
              state_q  <= ST_VXFER;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign vseg_o  = vseg_q;
  assign vpw_o   = vpw_q;
  assign set_o   = set_q;
  assign per_o   = per_q;
  assign eol_o   = eol_q;
  assign eof_o   = eof_q;

endmodule

// File: rtl/clkseq_pix_timer.sv
module clkseq_pix_timer #(
  parameter int NPIX = 3100,
  parameter int PP_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run_i,
  input  logic [PP_W-1:0] per_i,
  output logic [PP_W-1:0] k_o,
  output logic            pix_end_o,
  output logic            line_done_o
);
  localparam int PIX_W = (NPIX > 1) ? $clog2(NPIX) : 1;

  logic [PP_W-1:0]  k_q;
  logic [PIX_W-1:0] pix_q;
  logic             pix_end;
  logic             last_pix;

  assign pix_end  = run_i && (k_q == per_i - PP_W'(1));
  assign last_pix = (pix_q == PIX_W'(NPIX - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      k_q   <= '0;
      pix_q <= '0;
    end else if (!run_i) begin
      k_q   <= '0;
      pix_q <= '0;
    end else if (pix_end) begin
      k_q   <= '0;
      pix_q <= last_pix ? '0 : pix_q + PIX_W'(1);
    end else begin
      k_q <= k_q + PP_W'(1);
    end
  end

  assign k_o         = k_q;
  assign pix_end_o   = pix_end;
  assign line_done_o = pix_end && last_pix;

endmodule

// File: rtl/clkseq_phase_dec.sv
module clkseq_phase_dec
  import clkseq_pkg::*;
#(
  parameter int PP_W = 8
) (
  input  seq_state_e      state_i,
  input  logic [1:0]      vseg_i,
  input  logic [PP_W-1:0] k_i,
  input  logic [PP_W-1:0] per_i,
  output logic            v1_o,
  output logic            v2_o,
  output logic            h1_o,
  output logic            h2_o,
  output logic            rg_o,
  output logic            sample_o,
  output logic            busy_o,
  output logic            integ_o
);
  logic [PP_W-1:0] half;

  assign half = PP_W'(h2_span(32'(per_i)));

  always_comb begin
    v1_o     = 1'b0;
    v2_o     = 1'b0;
    h1_o     = 1'b1;
    h2_o     = 1'b0;
    rg_o     = 1'b0;
    sample_o = 1'b0;
    case (state_i)
      ST_VXFER: begin
        v1_o = (vseg_i == 2'd0);
        v2_o = (vseg_i == 2'd1);
      end
      ST_READ: begin
        h2_o     = (k_i < half);
        h1_o     = !(k_i < half);
        rg_o     = (k_i == '0);
        sample_o = (k_i == per_i - PP_W'(1));
      end
      default: ;
    endcase
  end

  assign busy_o  = (state_i != ST_IDLE);
  assign integ_o = (state_i == ST_INTEG);

endmodule

// File: rtl/fullframe_clkseq.sv
module fullframe_clkseq
  import clkseq_pkg::*;
#(
  parameter int LINES = 2056,
  parameter int NPIX  = 3100,
  parameter int INT_W = 24,
  parameter int VPW_W = 16,
  parameter int SET_W = 16,
  parameter int PP_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [INT_W-1:0] integ_len_i,
  input  logic [VPW_W-1:0] vpw_i,
  input  logic [SET_W-1:0] setup_i,
  input  logic [PP_W-1:0]  pix_per_i,
  output logic             v1_o,
  output logic             v2_o,
  output logic             h1_o,
  output logic             h2_o,
  output logic             rg_o,
  output logic             sample_o,
  output logic             busy_o,
  output logic             integ_o,
  output logic             eol_o,
  output logic             eof_o
);
  seq_state_e      state_w;
  logic [1:0]      vseg_w;
  logic [VPW_W-1:0] vpw_eff_w;
  logic [SET_W-1:0] set_eff_w;
  logic [PP_W-1:0]  per_eff_w;
  logic [PP_W-1:0]  k_w;
  logic             pix_end_w;
  logic             line_done_w;
  logic             read_w;

  assign read_w = (state_w == ST_READ);

  clkseq_frame_ctl #(
    .LINES(LINES), .INT_W(INT_W), .VPW_W(VPW_W), .SET_W(SET_W), .PP_W(PP_W)
  ) u_ctl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .integ_len_i(integ_len_i), .vpw_i(vpw_i), .setup_i(setup_i), .pix_per_i(pix_per_i),
    .line_done_i(line_done_w),
    .state_o(state_w), .vseg_o(vseg_w),
    .vpw_o(vpw_eff_w), .set_o(set_eff_w), .per_o(per_eff_w),
    .eol_o(eol_o), .eof_o(eof_o)
  );

  clkseq_pix_timer #(
    .NPIX(NPIX), .PP_W(PP_W)
  ) u_pix (
    .clk(clk), .rst_n(rst_n), .run_i(read_w), .per_i(per_eff_w),
    .k_o(k_w), .pix_end_o(pix_end_w), .line_done_o(line_done_w)
  );

  clkseq_phase_dec #(
    .PP_W(PP_W)
  ) u_dec (
    .state_i(state_w), .vseg_i(vseg_w), .k_i(k_w), .per_i(per_eff_w),
    .v1_o(v1_o), .v2_o(v2_o), .h1_o(h1_o), .h2_o(h2_o),
    .rg_o(rg_o), .sample_o(sample_o), .busy_o(busy_o), .integ_o(integ_o)
  );

endmodule

// File: rtl/clkseq_chk.sv
module clkseq_chk
  import clkseq_pkg::*;
#(
  parameter int LINES = 2056,
  parameter int NPIX  = 3100,
  parameter int VPW_W = 16,
  parameter int SET_W = 16,
  parameter int PP_W  = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             v1_o,
  input logic             v2_o,
  input logic             h1_o,
  input logic             h2_o,
  input logic             rg_o,
  input logic             sample_o,
  input logic             busy_o,
  input logic             integ_o,
  input logic             eol_o,
  input logic             eof_o,
  input logic [VPW_W-1:0] vpw_eff,
  input logic [SET_W-1:0] set_eff,
  input logic [PP_W-1:0]  per_eff,
  input logic             pix_end
);
  int unsigned eol_seen;
  int unsigned gap_cyc;
  logic        gap_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eol_seen  <= 0;
      gap_cyc   <= 0;
      gap_valid <= 1'b0;
    end else begin
      if (eol_o) begin
        eol_seen  <= eof_o ? 0 : eol_seen + 1;
        gap_cyc   <= 0;
        gap_valid <= !eof_o;
      end else begin
        gap_cyc <= gap_cyc + 1;
      end
    end
  end

  // R2
  integ_vlow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    integ_o |-> (!v1_o && !v2_o));

  // R3
  v_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(v1_o && v2_o));

  // R4
  v2_fall_h1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(v2_o) |-> (h1_o && !h2_o));

  // R5
  h_compl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(h1_o && h2_o));

  // R6
  rg_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rg_o |=> !rg_o);

  // R7
  sample_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_o |-> (pix_end && h1_o && !h2_o && !rg_o && !v1_o && !v2_o && !integ_o));

  // R7
  sample_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(h2_o) |-> !sample_o);

  // R8
  line_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eol_o && gap_valid) |->
      (gap_cyc + 1 == line_cycles(32'(vpw_eff), 32'(set_eff), 32'(per_eff), NPIX)));

  // R8
  line_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eof_o |-> (eol_seen == LINES - 1));

  // R9
  eol_after_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eol_o |-> $past(sample_o));

  // R9
  eof_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eof_o |-> (eol_o && !busy_o));

  // R9
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> eof_o);

  // R10
  accept_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(integ_o) |-> !$past(busy_o));

endmodule

bind fullframe_clkseq clkseq_chk #(
  .LINES(LINES), .NPIX(NPIX), .VPW_W(VPW_W), .SET_W(SET_W), .PP_W(PP_W)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .v1_o(v1_o), .v2_o(v2_o), .h1_o(h1_o), .h2_o(h2_o), .rg_o(rg_o),
  .sample_o(sample_o), .busy_o(busy_o), .integ_o(integ_o),
  .eol_o(eol_o), .eof_o(eof_o),
  .vpw_eff(vpw_eff_w), .set_eff(set_eff_w), .per_eff(per_eff_w),
  .pix_end(pix_end_w)
);

// File: tb/sim_fullframe_clkseq.sv
module sim_fullframe_clkseq;

  localparam int LINES = 3;
  localparam int NPIX  = 5;
  localparam int INT_W = 16;
  localparam int VPW_W = 8;
  localparam int SET_W = 8;
  localparam int PP_W  = 6;

  typedef struct packed {
    logic v1, v2, h1, h2, rg, smp, busy, integ, eol, eof;
  } obs_t;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [INT_W-1:0] il_in = '0;
  logic [VPW_W-1:0] vp_in = '0;
  logic [SET_W-1:0] su_in = '0;
  logic [PP_W-1:0]  pp_in = '0;
  logic v1, v2, h1, h2, rg, smp, busy, integ, eol, eof;

  fullframe_clkseq #(
    .LINES(LINES), .NPIX(NPIX), .INT_W(INT_W), .VPW_W(VPW_W), .SET_W(SET_W), .PP_W(PP_W)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start),
    .integ_len_i(il_in), .vpw_i(vp_in), .setup_i(su_in), .pix_per_i(pp_in),
    .v1_o(v1), .v2_o(v2), .h1_o(h1), .h2_o(h2), .rg_o(rg), .sample_o(smp),
    .busy_o(busy), .integ_o(integ), .eol_o(eol), .eof_o(eof)
  );

  obs_t  exp_q[$];
  int    checks = 0;
  int    errors = 0;
  string cur_tag = "R1";

  function automatic obs_t now_obs();
    return '{v1, v2, h1, h2, rg, smp, busy, integ, eol, eof};
  endfunction

  function automatic obs_t mk(bit a1, bit a2, bit b1, bit b2, bit r, bit s,
                              bit bz, bit it, bit el, bit ef);
    obs_t o;
    o = '{a1, a2, b1, b2, r, s, bz, it, el, ef};
    return o;
  endfunction

  function automatic string tag_of(obs_t a, obs_t e);
    if (a.v1 !== e.v1 || a.v2 !== e.v2)       return "R3";
    if (a.busy !== e.busy || a.integ !== e.integ) return "R2";
    if (a.h1 !== e.h1 || a.h2 !== e.h2)       return "R5";
    if (a.rg !== e.rg)                        return "R6";
    if (a.smp !== e.smp)                      return "R7";
    return "R9";
  endfunction

  // monitor: pops one expected item per cycle while the queue holds any
  obs_t mon_e;
  obs_t mon_a;
  always @(posedge clk) begin
    #3;
    if (exp_q.size() > 0) begin
      mon_e = exp_q.pop_front();
      mon_a = now_obs();
      checks++;
      if (mon_a !== mon_e) begin
        errors++;
        $display("FAIL %s [%s] got %b expected %b", tag_of(mon_a, mon_e), cur_tag, mon_a, mon_e);
      end
    end
  end

  // driver side: expected frame, built from the requirements
  task automatic push_frame(input int il, input int vp, input int su, input int pp,
                            input bit tail, output int n);
    int  il_e, vp_e, su_e, pp_e;
    bit  pend;
    il_e = (il < 1) ? 1 : il;
    vp_e = (vp < 1) ? 1 : vp;
    su_e = (su < 1) ? 1 : su;
    pp_e = (pp < 4) ? 4 : pp;
    pend = 1'b0;
    n = 0;
    for (int i = 0; i < il_e; i++) begin
      exp_q.push_back(mk(0, 0, 1, 0, 0, 0, 1, 1, 0, 0)); n++;
    end
    for (int ln = 0; ln < LINES; ln++) begin
      for (int c = 0; c < 3 * vp_e; c++) begin
        exp_q.push_back(mk(c < vp_e, (c >= vp_e) && (c < 2 * vp_e), 1, 0, 0, 0, 1, 0, pend, 0));
        pend = 1'b0; n++;
      end
      for (int c = 0; c < su_e; c++) begin
        exp_q.push_back(mk(0, 0, 1, 0, 0, 0, 1, 0, 0, 0)); n++;
      end
      for (int px = 0; px < NPIX; px++) begin
        for (int k = 0; k < pp_e; k++) begin
          exp_q.push_back(mk(0, 0, !(k < pp_e / 2), k < pp_e / 2, k == 0, k == pp_e - 1,
                             1, 0, 0, 0));
          n++;
        end
      end
      pend = 1'b1;
    end
    exp_q.push_back(mk(0, 0, 1, 0, 0, 0, 0, 0, 1, 1)); n++;
    if (tail) begin
      exp_q.push_back(mk(0, 0, 1, 0, 0, 0, 0, 0, 0, 0));
      exp_q.push_back(mk(0, 0, 1, 0, 0, 0, 0, 0, 0, 0));
    end
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic set_cfg(input int il, input int vp, input int su, input int pp);
    il_in = INT_W'(il);
    vp_in = VPW_W'(vp);
    su_in = SET_W'(su);
    pp_in = PP_W'(pp);
  endtask

  task automatic run_frame(input int il, input int vp, input int su, input int pp,
                           input string tag);
    int n;
    drain();
    @(negedge clk);
    cur_tag = tag;
    set_cfg(il, vp, su, pp);
    push_frame(il, vp, su, pp, 1'b1, n);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    drain();
  endtask

  task automatic check_idle(input string tag);
    obs_t a, e;
    a = now_obs();
    e = mk(0, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s idle levels got %b expected %b", tag, a, e);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check_idle("R1 in reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_idle("R1 after reset");

    // R2 R3 R4 R5 R6 R7 R8 R9: nominal frame
    run_frame(6, 3, 2, 4, "R8 nominal");
    // R5: odd pixel period, H2 high for floor(P/2)
    run_frame(2, 2, 3, 7, "R5 odd period");
    // R2 R3 R4 R5: zero/short settings raised to their floors
    run_frame(0, 0, 0, 1, "R4 floor values");

    // R10: start while busy ignored, config changes mid-frame ignored
    begin
      int n;
      drain();
      @(negedge clk);
      cur_tag = "R10 busy start";
      set_cfg(3, 2, 1, 5);
      push_frame(3, 2, 1, 5, 1'b1, n);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (2) @(negedge clk);
      set_cfg(9, 4, 6, 8);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (20) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      drain();
    end

    // R11: start presented in the end-of-frame cycle
    begin
      int n_a, n_b;
      drain();
      @(negedge clk);
      cur_tag = "R11 back-to-back";
      set_cfg(2, 1, 1, 4);
      push_frame(2, 1, 1, 4, 1'b0, n_a);
      push_frame(4, 2, 2, 6, 1'b1, n_b);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (n_a - 1) @(negedge clk);
      set_cfg(4, 2, 2, 6);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      drain();
    end

    repeat (3) @(negedge clk);
    check_idle("R1 final idle");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired, got hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule